// File: doc/BRIEF.md
# Prioritised Interrupt Request and Acknowledge Unit

This block sits next to an 8-bit processor core. It decides, at each instruction boundary, whether an interrupt is taken and which source is taken. It watches one nonmaskable request and three maskable requests, all active low. The nonmaskable request is caught on its falling edge and held until it is serviced. The maskable requests are level-sensitive and are examined only when the core signals the end of an instruction.

When a source wins, the block produces the following in the next cycle:
- a one-cycle take pulse;
- a source identifier;
- for the nonmaskable case only, the fixed restart address 0066h;
- the active-low machine-cycle-one and I/O-request strobes that mark the acknowledge cycle for the highest maskable source.

The block also keeps the interrupt enable flag and its saved copy. The core changes them through set, clear and restore pulses.

Top module: `irq_ack_ctrl`

## Requirements
- R1: During and after reset, `take_o`=0, `m1_n_o`=1, `iorq_n_o`=1, `ie_o`=0, `ie_save_o`=0, `src_id_o`=0 and `restart_addr_o`=0.
- R2: A high-to-low transition on `nmi_n` is captured as pending. At the next cycle with `instr_end`=1, it is taken whatever the values of `ie_o`, `busreq_n` and `mirq_n`. A level held low after that does not trigger it again.
- R3: A pending nonmaskable request wins over any maskable request at the same boundary, and no maskable request is taken at that boundary.
- R4: A maskable request is taken only in a cycle with `instr_end`=1, `ie_o`=1, `busreq_n`=1 and no pending nonmaskable request. When no request is taken, `take_o` stays 0.
- R5: Among the active maskable requests, bit 0 of `mirq_n` wins over bit 1, and bit 1 wins over bit 2.
- R6: The take pulse appears one cycle after the deciding `instr_end` cycle and lasts one cycle. `src_id_o` encodes the source as 0 for nonmaskable and i+1 for `mirq_n[i]`.
- R7: In the take cycle for `mirq_n[0]`, `m1_n_o` and `iorq_n_o` are both 0. For every other source they both stay 1, and outside a take cycle they also stay 1.
- R8: Taking the nonmaskable request clears `ie_o` and copies its prior value into `ie_save_o`. Taking a maskable request clears both flags. An `en_restore` pulse copies `ie_save_o` into `ie_o`.
- R9: An `en_set` pulse sets both flags and an `en_clr` pulse clears both. A take in the same cycle overrides either pulse.
- R10: A new falling edge on `nmi_n` in the same cycle as a nonmaskable take leaves the request pending, so it is taken again at the next boundary.
- R11: `restart_addr_o` is 0066h in a nonmaskable take cycle and 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| nmi_n | input | 1 | Nonmaskable request, falling-edge sensitive, synchronous to clk |
| mirq_n | input | 3 | Maskable requests, active low, bit 0 highest priority |
| busreq_n | input | 1 | Bus request, active low; blocks maskable sources |
| instr_end | input | 1 | High in the cycle where the current instruction ends |
| en_set | input | 1 | Set interrupt enable flag and saved copy |
| en_clr | input | 1 | Clear interrupt enable flag and saved copy |
| en_restore | input | 1 | Copy saved flag back into the enable flag |
| take_o | output | 1 | One-cycle pulse: an interrupt is being acknowledged |
| src_id_o | output | 2 | Serviced source: 0 nonmaskable, i+1 for maskable i |
| restart_addr_o | output | 16 | 0066h during a nonmaskable take, else 0 |
| m1_n_o | output | 1 | Active-low machine-cycle-one strobe of the acknowledge |
| iorq_n_o | output | 1 | Active-low I/O-request strobe of the acknowledge |
| ie_o | output | 1 | Interrupt enable flag |
| ie_save_o | output | 1 | Saved copy of the enable flag |

## Verification
The maskable path is swept over every combination of the enable flag, the bus request and the three request levels. This sweep separates the gating rules from the priority order, and it shows which source alone raises the acknowledge strobes. Each pattern is first held without an instruction end, to show that levels are sampled only at the boundary. The nonmaskable path is driven in three ways:
- against an active top maskable source, to check that it wins;
- while the bus is requested and the enable flag is clear, to check that neither blocks it;
- with the line left low, to check that a level does not trigger it again.

A falling edge placed exactly in the take cycle checks that the request is caught again, rather than lost when the pending flag clears.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  localparam int          ADDR_W       = 16;
  localparam logic [15:0] NMI_RESTART  = 16'h0066;
  localparam int          SRC_NMI_CODE = 0;
endpackage

// File: rtl/nmi_edge_latch.sv
module nmi_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_n,
  input  logic take_nmi,
  output logic pend_o
);
  logic nmi_q;
  logic pend_q, pend_d;
  logic fall;

  assign fall = nmi_q & ~nmi_n;

  always_comb begin
    pend_d = pend_q;
    if (take_nmi) pend_d = 1'b0;
    if (fall)     pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q  <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      nmi_q  <= nmi_n;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  // R10
  fall_pends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_q && !nmi_n) |=> pend_q);
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int N_MASK = 3
) (
  input  logic              instr_end,
  input  logic              nmi_pend,
  input  logic [N_MASK-1:0] mreq,
  input  logic              ie,
  input  logic              bus_hold,
  output logic              take_nmi,
  output logic              take_mask,
  output logic [N_MASK-1:0] gnt
);
  logic mask_ok;

  genvar g;
  generate
    for (g = 0; g < N_MASK; g++) begin : g_pri
      if (g == 0) begin : g_top
        assign gnt[g] = mreq[g] & mask_ok;
      end else begin : g_low
        assign gnt[g] = mreq[g] & ~(|mreq[g-1:0]) & mask_ok;
      end
    end
  endgenerate

  assign take_nmi  = instr_end & nmi_pend;
  assign mask_ok   = instr_end & ie & ~bus_hold & ~nmi_pend;
  assign take_mask = |gnt;
endmodule

// File: rtl/irq_ack_drive.sv
module irq_ack_drive #(
  parameter int N_MASK = 3,
  parameter int SRC_W  = $clog2(N_MASK + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         take_nmi,
  input  logic                         take_mask,
  input  logic [N_MASK-1:0]            gnt,
  output logic                         take_o,
  output logic [SRC_W-1:0]             src_o,
  output logic [irq_ack_pkg::ADDR_W-1:0] addr_o,
  output logic                         m1_n_o,
  output logic                         iorq_n_o
);
  import irq_ack_pkg::*;

  logic              take_d;
  logic [SRC_W-1:0]  src_d;
  logic [ADDR_W-1:0] addr_d;
  logic              strobe_d;
  logic              src_en;

  always_comb begin
    take_d   = take_nmi | take_mask;
    src_en   = take_d;
    src_d    = SRC_W'(SRC_NMI_CODE);
    if (!take_nmi) begin
      for (int i = 0; i < N_MASK; i++)
        if (gnt[i]) src_d = SRC_W'(i + 1);
    end
    addr_d   = take_nmi ? NMI_RESTART : '0;
    strobe_d = take_mask & ~take_nmi & gnt[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_o   <= 1'b0;
      src_o    <= '0;
      addr_o   <= '0;
      m1_n_o   <= 1'b1;
      iorq_n_o <= 1'b1;
    end else begin
      take_o   <= take_d;
      addr_o   <= addr_d;
      m1_n_o   <= ~strobe_d;
      iorq_n_o <= ~strobe_d;
      if (src_en) src_o <= src_d;
    end
  end
endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl #(
  parameter int N_MASK = 3,
  parameter int SRC_W  = $clog2(N_MASK + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_n,
  input  logic [N_MASK-1:0] mirq_n,
  input  logic              busreq_n,
  input  logic              instr_end,
  input  logic              en_set,
  input  logic              en_clr,
  input  logic              en_restore,
  output logic              take_o,
  output logic [SRC_W-1:0]  src_id_o,
  output logic [15:0]       restart_addr_o,
  output logic              m1_n_o,
  output logic              iorq_n_o,
  output logic              ie_o,
  output logic              ie_save_o
);
  logic rs1_q, rs2_q, rst_int_n;
  logic nmi_pend, take_nmi, take_mask;
  logic [N_MASK-1:0] gnt;
  logic ie_q, ie_d, sv_q, sv_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_int_n = rs2_q;

  nmi_edge_latch u_nmi (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .nmi_n    (nmi_n),
    .take_nmi (take_nmi),
    .pend_o   (nmi_pend)
  );

  irq_prio_arb #(.N_MASK(N_MASK)) u_arb (
    .instr_end (instr_end),
    .nmi_pend  (nmi_pend),
    .mreq      (~mirq_n),
    .ie        (ie_q),
    .bus_hold  (~busreq_n),
    .take_nmi  (take_nmi),
    .take_mask (take_mask),
    .gnt       (gnt)
  );

  irq_ack_drive #(.N_MASK(N_MASK), .SRC_W(SRC_W)) u_drv (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .take_nmi  (take_nmi),
    .take_mask (take_mask),
    .gnt       (gnt),
    .take_o    (take_o),
    .src_o     (src_id_o),
    .addr_o    (restart_addr_o),
    .m1_n_o    (m1_n_o),
    .iorq_n_o  (iorq_n_o)
  );

  always_comb begin
    ie_d = ie_q;
    sv_d = sv_q;
    if (take_nmi) begin
      ie_d = 1'b0;
      sv_d = ie_q;
    end else if (take_mask || en_clr) begin
      ie_d = 1'b0;
      sv_d = 1'b0;
    end else if (en_set) begin
      ie_d = 1'b1;
      sv_d = 1'b1;
    end else if (en_restore) begin
      ie_d = sv_q;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ie_q <= 1'b0;
      sv_q <= 1'b0;
    end else begin
      ie_q <= ie_d;
      sv_q <= sv_d;
    end
  end

  assign ie_o      = ie_q;
  assign ie_save_o = sv_q;

  // R4
  take_needs_end_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    take_o |-> $past(instr_end));
  // R7
  int0_strobes_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (take_o && src_id_o == SRC_W'(1)) |-> (!m1_n_o && !iorq_n_o));
  // R7
  strobes_excl_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!m1_n_o || !iorq_n_o) |-> (take_o && src_id_o == SRC_W'(1)));
  // R8
  ie_cleared_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    take_o |-> !ie_o);
  // R11
  addr_only_nmi_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (restart_addr_o != 16'h0) |-> (take_o && src_id_o == SRC_W'(0)));
endmodule

// File: tb/sim_irq_ack_ctrl.sv
`timescale 1ns/1ps
module sim_irq_ack_ctrl;
  logic clk = 1'b0;
  logic rst_n, nmi_n, busreq_n, instr_end, en_set, en_clr, en_restore;
  logic [2:0] mirq_n;
  logic take_o, m1_n_o, iorq_n_o, ie_o, ie_save_o;
  logic [1:0] src_id_o;
  logic [15:0] restart_addr_o;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_ack_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .mirq_n(mirq_n),
    .busreq_n(busreq_n), .instr_end(instr_end), .en_set(en_set),
    .en_clr(en_clr), .en_restore(en_restore), .take_o(take_o),
    .src_id_o(src_id_o), .restart_addr_o(restart_addr_o),
    .m1_n_o(m1_n_o), .iorq_n_o(iorq_n_o), .ie_o(ie_o), .ie_save_o(ie_save_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk_take(input bit t, input int src, input int addr, input bit strobe, input string tag);
    chk(take_o == t, {tag, " take"}, take_o, t);
    if (t) chk(src_id_o == src, {tag, " src"}, src_id_o, src);
    chk(restart_addr_o == addr, {tag, " addr"}, restart_addr_o, addr);
    chk(m1_n_o == !strobe, {tag, " m1_n"}, m1_n_o, !strobe);
    chk(iorq_n_o == !strobe, {tag, " iorq_n"}, iorq_n_o, !strobe);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; nmi_n = 1; mirq_n = 3'b111; busreq_n = 1; instr_end = 0;
    en_set = 0; en_clr = 0; en_restore = 0;
    repeat (3) cyc();
    // R1 reset state
    chk_take(0, 0, 0, 0, "R1");
    chk(ie_o == 0 && ie_save_o == 0, "R1 flags", {ie_o, ie_save_o}, 0);
    chk(src_id_o == 0, "R1 src", src_id_o, 0);
    rst_n = 1;
    repeat (4) cyc();

    // Maskable sweep: R4 R5 R6 R7 R8
    for (int ie = 0; ie < 2; ie++)
      for (int br = 0; br < 2; br++)
        for (int p = 0; p < 8; p++) begin
          bit exp_t; int exp_src;
          en_set = ie; en_clr = !ie; cyc();
          en_set = 0; en_clr = 0;
          mirq_n = p[2:0]; busreq_n = br[0]; cyc();
          chk(take_o == 0, "R4 no end no take", take_o, 0);
          instr_end = 1; cyc();
          instr_end = 0; mirq_n = 3'b111; busreq_n = 1;
          exp_t = (ie == 1) && (br == 1) && (p != 7);
          exp_src = !p[0] ? 1 : (!p[1] ? 2 : 3);
          chk_take(exp_t, exp_src, 0, exp_t && exp_src == 1, "R5 R6 R7 sweep");
          chk(ie_o == (exp_t ? 0 : ie), "R8 ie after", ie_o, exp_t ? 0 : ie);
          chk(ie_save_o == (exp_t ? 0 : ie), "R8 save after", ie_save_o, exp_t ? 0 : ie);
          cyc();
          chk_take(0, 0, 0, 0, "R6 pulse ends");
        end

    // R9 take overrides en_set in same cycle
    en_set = 1; cyc(); en_set = 0;
    mirq_n = 3'b101; instr_end = 1; en_set = 1; cyc();
    instr_end = 0; en_set = 0; mirq_n = 3'b111;
    chk_take(1, 2, 0, 0, "R9 take");
    chk(ie_o == 0, "R9 ie", ie_o, 0);
    en_set = 1; cyc(); en_set = 0; cyc();
    chk(ie_o == 1 && ie_save_o == 1, "R9 set", {ie_o, ie_save_o}, 3);

    // R3 NMI beats INT0, R8 save
    mirq_n = 3'b110; nmi_n = 0; cyc();
    instr_end = 1; cyc();
    instr_end = 0;
    chk_take(1, 0, 16'h0066, 0, "R3 R11 nmi wins");
    chk(ie_o == 0 && ie_save_o == 1, "R8 nmi save", {ie_o, ie_save_o}, 1);
    cyc();
    chk_take(0, 0, 0, 0, "R11 addr clears");
    // R2 held level no retrigger
    busreq_n = 0; instr_end = 1; cyc(); instr_end = 0;
    chk(take_o == 0, "R2 level no retrigger", take_o, 0);
    en_restore = 1; cyc(); en_restore = 0; cyc();
    chk(ie_o == 1, "R8 restore", ie_o, 1);
    en_clr = 1; cyc(); en_clr = 0; mirq_n = 3'b111;

    // R10 recapture in take cycle; R2 with ie=0 and bus requested
    nmi_n = 1; cyc();
    nmi_n = 0; cyc();
    nmi_n = 1; cyc();
    nmi_n = 0; instr_end = 1; cyc();
    chk_take(1, 0, 16'h0066, 0, "R2 nmi ignores ie and bus");
    cyc();
    chk_take(1, 0, 16'h0066, 0, "R10 recaptured");
    chk(ie_save_o == 0, "R8 save of clear ie", ie_save_o, 0);
    instr_end = 0; cyc();
    chk(take_o == 0, "R10 drained", take_o, 0);
    busreq_n = 1; nmi_n = 1; cyc();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule